// File: doc/BRIEF.md
# Switch Action Encoder and Event Strobe

This block sits between two debounced operator switches and a processor that selects one of several video inputs. One switch is a latching level switch that freezes the current input. The other is a spring-return toggle that emits a short high pulse when pushed left (step forward) or right (step backward). The processor has a single interrupt pin for both switches. The block therefore produces one shared active-low event strobe, and it writes a small action code into a word of a local storage block. The processor reads that word when the interrupt fires.

A change of the level switch becomes a strobe pulse of fixed width. The pulse is formed by comparing the switch with a copy of itself delayed by a parameterised number of cycles. The toggle pulses are merged onto the same line by an AND of active-low terms. Each detected action, whether an edge of the level switch or a rising edge of a toggle input, causes a single-cycle write request. The request carries a fixed slot address and a code that names the action. After reset, the first sampled value of each switch is taken as its resting state, so a switch that is already on does not raise a false event.

Top module: `switch_action_encoder`

## Requirements
- R1: While rst_ni is low, evt_n_o is 1, wr_en_o is 0 and wr_data_o is 0.
- R2: A 0-to-1 change of lvl_sw_i writes code 1 (engage): wr_en_o is high for one cycle with wr_data_o = 1, in the cycle after the clock edge that first samples the new level.
- R3: A 1-to-0 change of lvl_sw_i writes code 2 (release), with the same timing as R2.
- R4: A rising edge of step_left_i writes code 3, and a rising edge of step_right_i writes code 4, with the same timing as R2.
- R5: Every write presents wr_addr_o = SLOT. When wr_en_o is low, wr_data_o is 0.
- R6: When several actions are detected at the same edge, only one write is issued, and it carries the highest code among them (right 4 over left 3 over release 2 over engage 1).
- R7: Each change of lvl_sw_i drives evt_n_o low for exactly DELAY consecutive cycles, starting one cycle after the edge that samples the change.
- R8: evt_n_o is low in every cycle after an edge at which step_left_i or step_right_i is sampled high.
- R9: The first value of lvl_sw_i, step_left_i and step_right_i sampled after reset is taken as the resting state and produces neither a write nor a level strobe pulse.
- R10: A toggle input held high for many cycles produces exactly one write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| lvl_sw_i | input | 1 | Debounced level switch, 1 = engaged |
| step_left_i | input | 1 | Debounced left toggle pulse, active high |
| step_right_i | input | 1 | Debounced right toggle pulse, active high |
| evt_n_o | output | 1 | Shared event strobe to the processor, active low |
| wr_en_o | output | 1 | One-cycle write request to the storage block |
| wr_addr_o | output | ADDR_W | Storage slot for the action code (constant SLOT) |
| wr_data_o | output | CODE_W | Action code 1..4, 0 when idle |

## Verification
The bench first holds the level switch engaged through reset. This shows that the resting state is learned and not reported as a false engage. Single level changes in each direction then check that the two edge codes are told apart and that the strobe width equals the delay length. Short and long toggle pulses separate edge detection from level sensing: a held toggle must write once but keep the strobe low. Coincident actions (left with right, level with left) check the priority rule and show that only one write is issued.

// File: rtl/swact_pkg.sv
package swact_pkg;
  localparam int CODE_W = 8;
  localparam int NUM_ACT = 4;

  typedef enum logic [CODE_W-1:0] {
    ACT_NONE    = 8'd0,
    ACT_ENGAGE  = 8'd1,
    ACT_RELEASE = 8'd2,
    ACT_LEFT    = 8'd3,
    ACT_RIGHT   = 8'd4
  } act_code_e;

  // hit vector bit positions, ascending priority
  localparam int HIT_ENGAGE  = 0;
  localparam int HIT_RELEASE = 1;
  localparam int HIT_LEFT    = 2;
  localparam int HIT_RIGHT   = 3;
endpackage

// File: rtl/swact_edge.sv
module swact_edge (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic primed_i,
  input  logic sig_i,
  output logic chg_o
);
  logic sig_q;
  logic prev;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sig_q <= 1'b0;
    else         sig_q <= sig_i;
  end

  // before priming the current sample is its own history
  assign prev  = primed_i ? sig_q : sig_i;
  assign chg_o = sig_i ^ prev;
endmodule

// File: rtl/swact_delay.sv
module swact_delay #(
  parameter int DELAY = 256
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic primed_i,
  input  logic sig_i,
  output logic old_o
);
  logic [DELAY-1:0] hist_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        hist_q[0] <= 1'b0;
    else                hist_q[0] <= sig_i;
  end

  for (genvar s = 1; s < DELAY; s++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)       hist_q[s] <= 1'b0;
      else if (primed_i) hist_q[s] <= hist_q[s-1];
      else               hist_q[s] <= sig_i;
    end
  end

  assign old_o = primed_i ? hist_q[DELAY-1] : sig_i;
endmodule

// File: rtl/swact_encode.sv
module swact_encode
  import swact_pkg::*;
#(
  parameter int ADDR_W = 3,
  parameter int SLOT   = 0
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [NUM_ACT-1:0]  hit_i,
  output logic                wr_en_o,
  output logic [ADDR_W-1:0]   wr_addr_o,
  output logic [CODE_W-1:0]   wr_data_o
);
  act_code_e code_d;

  // later index overrides: highest code wins
  always_comb begin
    code_d = ACT_NONE;
    for (int i = 0; i < NUM_ACT; i++) begin
      if (hit_i[i]) code_d = act_code_e'(CODE_W'(i + 1));
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_en_o   <= 1'b0;
      wr_data_o <= '0;
    end else begin
      wr_en_o   <= |hit_i;
      wr_data_o <= code_d;
    end
  end

  assign wr_addr_o = ADDR_W'(SLOT);
endmodule

// File: rtl/switch_action_encoder.sv
module switch_action_encoder
  import swact_pkg::*;
#(
  parameter int DELAY  = 256,
  parameter int DEPTH  = 8,
  parameter int SLOT   = 5,
  localparam int ADDR_W = $clog2(DEPTH)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              lvl_sw_i,
  input  logic              step_left_i,
  input  logic              step_right_i,
  output logic              evt_n_o,
  output logic              wr_en_o,
  output logic [ADDR_W-1:0] wr_addr_o,
  output logic [CODE_W-1:0] wr_data_o
);
  localparam int NSRC = 3;

  logic              primed_q;
  logic [NSRC-1:0]   src;
  logic [NSRC-1:0]   chg;
  logic              lvl_old;
  logic              lvl_pulse;
  logic [NUM_ACT-1:0] hit;

  assign src = {step_right_i, step_left_i, lvl_sw_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) primed_q <= 1'b0;
    else         primed_q <= 1'b1;
  end

  for (genvar k = 0; k < NSRC; k++) begin : g_edge
    swact_edge u_edge (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .primed_i (primed_q),
      .sig_i    (src[k]),
      .chg_o    (chg[k])
    );
  end

  swact_delay #(.DELAY(DELAY)) u_delay (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .primed_i (primed_q),
    .sig_i    (lvl_sw_i),
    .old_o    (lvl_old)
  );

  assign lvl_pulse = lvl_sw_i ^ lvl_old;

  assign hit[HIT_ENGAGE]  = chg[0] &  lvl_sw_i;
  assign hit[HIT_RELEASE] = chg[0] & ~lvl_sw_i;
  assign hit[HIT_LEFT]    = chg[1] &  step_left_i;
  assign hit[HIT_RIGHT]   = chg[2] &  step_right_i;

  // active-low merge: strobe low if any source active
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) evt_n_o <= 1'b1;
    else         evt_n_o <= ~lvl_pulse & ~step_left_i & ~step_right_i;
  end

  swact_encode #(.ADDR_W(ADDR_W), .SLOT(SLOT)) u_encode (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .hit_i     (hit),
    .wr_en_o   (wr_en_o),
    .wr_addr_o (wr_addr_o),
    .wr_data_o (wr_data_o)
  );
endmodule

// File: rtl/switch_action_encoder_chk.sv
module switch_action_encoder_chk #(
  parameter int ADDR_W = 3,
  parameter int CODE_W = 8,
  parameter int SLOT   = 5
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              lvl_sw_i,
  input logic              step_left_i,
  input logic              step_right_i,
  input logic              evt_n_o,
  input logic              wr_en_o,
  input logic [ADDR_W-1:0] wr_addr_o,
  input logic [CODE_W-1:0] wr_data_o
);
  logic seen_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) seen_q <= 1'b0;
    else         seen_q <= 1'b1;
  end

  assert_wr_slot_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_o |-> (wr_addr_o == ADDR_W'(SLOT)) && (wr_data_o >= 1) && (wr_data_o <= 4));

  assert_idle_data_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en_o |-> (wr_data_o == '0));

  assert_engage_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (seen_q && $rose(lvl_sw_i) && !step_left_i && !step_right_i)
      |=> (wr_en_o && wr_data_o == CODE_W'(1)));

  assert_release_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (seen_q && $fell(lvl_sw_i) && !step_left_i && !step_right_i)
      |=> (wr_en_o && wr_data_o == CODE_W'(2)));

  assert_right_wins_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (seen_q && $rose(step_right_i)) |=> (wr_en_o && wr_data_o == CODE_W'(4)));

  assert_step_strobe_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_left_i || step_right_i) |=> !evt_n_o);

  assert_hold_one_write_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (seen_q && step_left_i && $past(step_left_i) && !$rose(step_right_i)
       && $stable(lvl_sw_i)) |=> !wr_en_o);
endmodule

bind switch_action_encoder switch_action_encoder_chk #(
  .ADDR_W(ADDR_W), .CODE_W(swact_pkg::CODE_W), .SLOT(SLOT)
) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .lvl_sw_i     (lvl_sw_i),
  .step_left_i  (step_left_i),
  .step_right_i (step_right_i),
  .evt_n_o      (evt_n_o),
  .wr_en_o      (wr_en_o),
  .wr_addr_o    (wr_addr_o),
  .wr_data_o    (wr_data_o)
);

// File: tb/switch_action_encoder_bench.sv
`timescale 1ns/1ps
module switch_action_encoder_bench;
  localparam int DELAY  = 256;
  localparam int DEPTH  = 8;
  localparam int SLOT   = 5;
  localparam int ADDR_W = $clog2(DEPTH);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic lvl = 1'b0, left = 1'b0, right = 1'b0;
  logic evt_n, wr_en;
  logic [ADDR_W-1:0] wr_addr;
  logic [7:0] wr_data;

  always #4 clk = ~clk;

  switch_action_encoder #(.DELAY(DELAY), .DEPTH(DEPTH), .SLOT(SLOT)) u_switch_action_encoder (
    .clk_i(clk), .rst_ni(rst_n), .lvl_sw_i(lvl), .step_left_i(left),
    .step_right_i(right), .evt_n_o(evt_n), .wr_en_o(wr_en),
    .wr_addr_o(wr_addr), .wr_data_o(wr_data)
  );

  int vectors = 0, miscompares = 0;
  string tag = "R1";
  bit done = 1'b0;

  // behavioural reference
  bit m_first = 1'b1;
  bit m_pl, m_pa, m_pb, m_old;
  bit m_hist[$];
  bit e_evt_n = 1'b1, e_wr = 1'b0;
  int e_data = 0, m_code;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_first = 1'b1; m_hist.delete();
      e_evt_n = 1'b1; e_wr = 1'b0; e_data = 0;
    end else begin
      if (m_first) begin
        m_hist.delete();
        for (int i = 0; i < DELAY; i++) m_hist.push_back(lvl);
        m_pl = lvl; m_pa = left; m_pb = right; m_first = 1'b0;
      end
      m_old = m_hist.pop_front();
      m_hist.push_back(lvl);
      m_code = 0;
      if (lvl && !m_pl)   m_code = 1;
      if (!lvl && m_pl)   m_code = 2;
      if (left && !m_pa)  m_code = 3;
      if (right && !m_pb) m_code = 4;
      e_evt_n = !((lvl ^ m_old) || left || right);
      e_wr = (m_code != 0);
      e_data = m_code;
      m_pl = lvl; m_pa = left; m_pb = right;
    end
  end

  always @(negedge clk) begin
    if (!done) begin
      vectors++;
      if (evt_n !== e_evt_n || wr_en !== e_wr || wr_data !== 8'(e_data)
          || wr_addr !== ADDR_W'(SLOT)) begin
        miscompares++;
        $display("FAIL %s evt_n=%b exp %b wr_en=%b exp %b data=%0d exp %0d addr=%0d exp %0d",
                 tag, evt_n, e_evt_n, wr_en, e_wr, wr_data, e_data, wr_addr, SLOT);
      end
    end
  end

  task automatic chk(input bit ok, input string t, input int act, input int exp);
    vectors++;
    if (!ok) begin
      miscompares++;
      $display("FAIL %s actual=%0d expected=%0d", t, act, exp);
    end
  endtask

  task automatic run(input int n, output int w, output int lo, output int last);
    w = 0; lo = 0; last = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (wr_en) begin w++; last = int'(wr_data); end
      if (!evt_n) lo++;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      miscompares++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    int w, lo, last;
    lvl = 1'b1;
    repeat (3) @(negedge clk);
    chk(evt_n && !wr_en && wr_data == 0, "R1 reset outputs", {evt_n, wr_en}, 2);

    // R9: level already engaged at reset release
    tag = "R9"; rst_n = 1'b1;
    run(300, w, lo, last);
    chk(w == 0, "R9 writes", w, 0);
    chk(lo == 0, "R9 strobe lows", lo, 0);

    tag = "R3"; lvl = 1'b0;
    run(300, w, lo, last);
    chk(w == 1, "R3 writes", w, 1);
    chk(last == 2, "R3 code", last, 2);
    chk(lo == DELAY, "R7 release width", lo, DELAY);

    tag = "R2"; lvl = 1'b1;
    run(300, w, lo, last);
    chk(w == 1 && last == 1, "R2 engage code", last, 1);
    chk(lo == DELAY, "R7 engage width", lo, DELAY);

    tag = "R4"; left = 1'b1;
    run(2, w, lo, last);
    left = 1'b0;
    chk(w == 1 && last == 3, "R4 left code", last, 3);
    run(5, w, lo, last);
    right = 1'b1;
    run(1, w, lo, last);
    right = 1'b0;
    chk(w == 1 && last == 4, "R4 right code", last, 4);
    chk(wr_addr == ADDR_W'(SLOT), "R5 slot", int'(wr_addr), SLOT);
    run(5, w, lo, last);
    chk(w == 0 && wr_data == 0, "R5 idle data", int'(wr_data), 0);

    tag = "R10"; left = 1'b1;
    run(20, w, lo, last);
    chk(w == 1, "R10 held writes", w, 1);
    chk(lo == 20, "R8 held strobe lows", lo, 20);
    left = 1'b0;
    run(5, w, lo, last);
    chk(lo == 0, "R8 strobe released", lo, 0);

    tag = "R6"; left = 1'b1; right = 1'b1;
    run(3, w, lo, last);
    left = 1'b0; right = 1'b0;
    chk(w == 1 && last == 4, "R6 left+right", last, 4);
    run(5, w, lo, last);
    lvl = 1'b0; left = 1'b1;
    run(1, w, lo, last);
    left = 1'b0;
    chk(w == 1 && last == 3, "R6 release+left", last, 3);
    run(300, w, lo, last);
    chk(w == 0, "R6 single write", w, 0);

    // mid-run reset with level engaged
    tag = "R1"; rst_n = 1'b0; lvl = 1'b1;
    run(2, w, lo, last);
    chk(evt_n && !wr_en, "R1 second reset", {evt_n, wr_en}, 2);
    tag = "R9"; rst_n = 1'b1;
    run(300, w, lo, last);
    chk(w == 0 && lo == 0, "R9 after second reset", w + lo, 0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule